// File: doc/BRIEF.md
# Per-Interrupt Distributor State Tracker

This block holds the state of every interrupt ID in a distributor that serves several CPUs. For each ID it stores five fields with one bit per CPU: enabled, pending latch, active, sampled line level and group. It also stores two single flags: edge-triggered and delivery model. It keeps an 8-bit priority that is banked per CPU for internal IDs and shared for all other IDs. Each interrupt line input is registered as the level field. Rising edges on those lines set the pending latch of edge-triggered interrupts.

A register decoder or the acknowledge/deactivate logic drives the block through separate ports. A general set port and a general clear port update one field for a set of CPUs. An acknowledge port drops the pending latch. A deactivate port drops the active state. A write port stores a priority. A combinational query port returns the enabled, pending, active, group and priority values for one (ID, CPU) pair. A legacy mode input selects whether the line level counts towards the pending view.

Top module: `irq_dist_state`

## Requirements
- R1: While reset is low and after reset is released, every field, flag and priority reads zero.
- R2: The set and clear ports act on the field selected by a 3-bit code: 0 enabled, 1 pending latch, 2 active, 3 group, 4 edge-triggered flag, 5 delivery-model flag; codes 6 and 7 change nothing. For codes 0 to 3, only the CPUs whose bit is high in the mask change. Codes 4 and 5 ignore the mask. A command shows on the query port one cycle after it is issued.
- R3: When the set and clear ports target the same field of the same ID in the same cycle, the set takes effect.
- R4: Each line input bit (bit ID*NCPU+CPU of the line bus) is registered as the level bit. In normal mode, a level-sensitive interrupt (edge flag 0) reads pending on the cycle after its line is high.
- R5: In legacy mode, the pending view equals the pending latch only. A high line does not make it read pending.
- R6: For an edge-triggered interrupt, a 0-to-1 transition of a CPU's line bit sets that CPU's pending latch. A line that stays high does not set the latch again after it has been cleared.
- R7: Clearing the pending latch of a level-sensitive interrupt whose line is still high leaves it reading pending in normal mode.
- R8: An acknowledge clears the pending latch of all CPUs when the ID's delivery-model flag is set. Otherwise it clears only the acknowledging CPU's bit.
- R9: A deactivate of an ID below NINTERNAL (32) clears only the requesting CPU's active bit. A deactivate of any higher ID clears the active bits of all CPUs.
- R10: A priority write to an ID below NINTERNAL stores into the writing CPU's bank and is read back only for that CPU. A write to a higher ID is read back for every CPU.
- R11: Query outputs are combinational in the query ID and CPU and reflect the stored state in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| legacy_mode | input | 1 | 1: pending view ignores line level |
| irq_line | input | NIRQ*NCPU | Line inputs, bit ID*NCPU+CPU |
| set_valid | input | 1 | Set command strobe |
| set_field | input | 3 | Field code for set |
| set_id | input | IDW | Interrupt ID for set |
| set_mask | input | NCPU | CPU mask for set |
| clr_valid | input | 1 | Clear command strobe |
| clr_field | input | 3 | Field code for clear |
| clr_id | input | IDW | Interrupt ID for clear |
| clr_mask | input | NCPU | CPU mask for clear |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_id | input | IDW | Acknowledged ID |
| ack_cpu | input | CPUW | Acknowledging CPU |
| deact_valid | input | 1 | Deactivate strobe |
| deact_id | input | IDW | Deactivated ID |
| deact_cpu | input | CPUW | Requesting CPU |
| prio_we | input | 1 | Priority write strobe |
| prio_id | input | IDW | Priority write ID |
| prio_cpu | input | CPUW | Writing CPU |
| prio_val | input | PRIO_W | Priority value |
| q_id | input | IDW | Query ID |
| q_cpu | input | CPUW | Query CPU |
| q_enabled | output | 1 | Enabled bit |
| q_pending | output | 1 | Pending view |
| q_active | output | 1 | Active bit |
| q_group | output | 1 | Group bit |
| q_prio | output | PRIO_W | Priority |

## Verification
The assertions run on every cycle and cover these properties: the zero state right after reset, a group set showing on the next cycle, set winning over a same-cycle clear, a shared-ID deactivate clearing the active bit for whatever CPU is queried, and the queried priority staying unchanged when no write occurs. Edge detection on the lines, the legacy versus normal pending view, level-held pending after a latch clear, the acknowledge mask chosen by the delivery model, and priority banking need a history of line values and flags. Only the bench's scenarios show these, with a reference model compared on every clock.

// File: rtl/irqst_pkg.sv
package irqst_pkg;

    typedef enum logic [2:0] {
        FLD_ENABLE = 3'd0,
        FLD_PEND   = 3'd1,
        FLD_ACTIVE = 3'd2,
        FLD_GROUP  = 3'd3,
        FLD_EDGE   = 3'd4,
        FLD_MODEL  = 3'd5
    } field_e;

endpackage

// File: rtl/irqst_fields.sv
module irqst_fields
    import irqst_pkg::*;
#(
    parameter int NCPU      = 4,
    parameter int NINTERNAL = 32,
    parameter int NIRQ      = 96,
    parameter int IDW       = 7,
    parameter int CPUW      = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NIRQ*NCPU-1:0] irq_line,
    input  logic                 set_valid,
    input  logic [2:0]           set_field,
    input  logic [IDW-1:0]       set_id,
    input  logic [NCPU-1:0]      set_mask,
    input  logic                 clr_valid,
    input  logic [2:0]           clr_field,
    input  logic [IDW-1:0]       clr_id,
    input  logic [NCPU-1:0]      clr_mask,
    input  logic                 ack_valid,
    input  logic [IDW-1:0]       ack_id,
    input  logic [CPUW-1:0]      ack_cpu,
    input  logic                 deact_valid,
    input  logic [IDW-1:0]       deact_id,
    input  logic [CPUW-1:0]      deact_cpu,
    output logic [NCPU-1:0]      en_o    [NIRQ],
    output logic [NCPU-1:0]      pend_o  [NIRQ],
    output logic [NCPU-1:0]      act_o   [NIRQ],
    output logic [NCPU-1:0]      lvl_o   [NIRQ],
    output logic [NCPU-1:0]      grp_o   [NIRQ],
    output logic [NIRQ-1:0]      edge_o,
    output logic [NIRQ-1:0]      model_o
);

    typedef struct packed {
        logic [NCPU-1:0] en;
        logic [NCPU-1:0] pend;
        logic [NCPU-1:0] act;
        logic [NCPU-1:0] lvl;
        logic [NCPU-1:0] grp;
        logic            edge_trig;
        logic            model;
    } slot_t;

    slot_t st_d [NIRQ];
    slot_t st_q [NIRQ];

    // Apply one set (setv=1) or clear (setv=0) command to a slot.
    function automatic slot_t apply_cmd(slot_t s, logic [2:0] f,
                                        logic [NCPU-1:0] m, logic setv);
        slot_t r = s;
        case (field_e'(f))
            FLD_ENABLE: r.en   = setv ? (s.en   | m) : (s.en   & ~m);
            FLD_PEND:   r.pend = setv ? (s.pend | m) : (s.pend & ~m);
            FLD_ACTIVE: r.act  = setv ? (s.act  | m) : (s.act  & ~m);
            FLD_GROUP:  r.grp  = setv ? (s.grp  | m) : (s.grp  & ~m);
            FLD_EDGE:   r.edge_trig = setv;
            FLD_MODEL:  r.model     = setv;
            default:    r = s;
        endcase
        return r;
    endfunction

    logic [NCPU-1:0] ack_bit;
    logic [NCPU-1:0] deact_bit;

    assign ack_bit   = NCPU'(1) << ack_cpu;
    assign deact_bit = NCPU'(1) << deact_cpu;

    always_comb begin
        for (int i = 0; i < NIRQ; i++) begin
            logic [NCPU-1:0] line_i;
            line_i  = irq_line[i*NCPU +: NCPU];
            st_d[i] = st_q[i];
            // clears first, so that any set in the same cycle wins
            if (clr_valid && clr_id == IDW'(i))
                st_d[i] = apply_cmd(st_d[i], clr_field, clr_mask, 1'b0);
            if (ack_valid && ack_id == IDW'(i))
                st_d[i].pend = st_d[i].pend & (st_q[i].model ? '0 : ~ack_bit);
            if (deact_valid && deact_id == IDW'(i))
                st_d[i].act = st_d[i].act & ((i < NINTERNAL) ? ~deact_bit : '0);
            if (set_valid && set_id == IDW'(i))
                st_d[i] = apply_cmd(st_d[i], set_field, set_mask, 1'b1);
            if (st_q[i].edge_trig)
                st_d[i].pend = st_d[i].pend | (line_i & ~st_q[i].lvl);
            st_d[i].lvl = line_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NIRQ; i++) st_q[i] <= '0;
        end else begin
            for (int i = 0; i < NIRQ; i++) st_q[i] <= st_d[i];
        end
    end

    always_comb begin
        for (int i = 0; i < NIRQ; i++) begin
            en_o[i]    = st_q[i].en;
            pend_o[i]  = st_q[i].pend;
            act_o[i]   = st_q[i].act;
            lvl_o[i]   = st_q[i].lvl;
            grp_o[i]   = st_q[i].grp;
            edge_o[i]  = st_q[i].edge_trig;
            model_o[i] = st_q[i].model;
        end
    end

endmodule

// File: rtl/irqst_prio.sv
module irqst_prio #(
    parameter int NCPU      = 4,
    parameter int NINTERNAL = 32,
    parameter int NIRQ      = 96,
    parameter int PRIO_W    = 8,
    parameter int IDW       = 7,
    parameter int CPUW      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prio_we,
    input  logic [IDW-1:0]    prio_id,
    input  logic [CPUW-1:0]   prio_cpu,
    input  logic [PRIO_W-1:0] prio_val,
    input  logic [IDW-1:0]    rd_id,
    input  logic [CPUW-1:0]   rd_cpu,
    output logic [PRIO_W-1:0] rd_prio
);

    localparam int NSHARED = NIRQ - NINTERNAL;
    localparam int IBW     = $clog2(NINTERNAL);
    localparam int SHW     = $clog2(NSHARED);

    logic [PRIO_W-1:0] bank_d   [NINTERNAL][NCPU];
    logic [PRIO_W-1:0] bank_q   [NINTERNAL][NCPU];
    logic [PRIO_W-1:0] shared_d [NSHARED];
    logic [PRIO_W-1:0] shared_q [NSHARED];

    logic [IDW-1:0] wr_off;
    logic [IDW-1:0] rd_off;

    assign wr_off = prio_id - IDW'(NINTERNAL);
    assign rd_off = rd_id - IDW'(NINTERNAL);

    always_comb begin
        bank_d   = bank_q;
        shared_d = shared_q;
        if (prio_we) begin
            if (prio_id < IDW'(NINTERNAL))
                bank_d[prio_id[IBW-1:0]][prio_cpu] = prio_val;
            else
                shared_d[wr_off[SHW-1:0]] = prio_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NINTERNAL; i++)
                for (int c = 0; c < NCPU; c++) bank_q[i][c] <= '0;
            for (int i = 0; i < NSHARED; i++) shared_q[i] <= '0;
        end else begin
            bank_q   <= bank_d;
            shared_q <= shared_d;
        end
    end

    assign rd_prio = (rd_id < IDW'(NINTERNAL)) ? bank_q[rd_id[IBW-1:0]][rd_cpu]
                                               : shared_q[rd_off[SHW-1:0]];

endmodule

// File: rtl/irqst_query.sv
module irqst_query #(
    parameter int NCPU = 4,
    parameter int NIRQ = 96,
    parameter int IDW  = 7,
    parameter int CPUW = 2
) (
    input  logic            legacy_mode,
    input  logic [IDW-1:0]  q_id,
    input  logic [CPUW-1:0] q_cpu,
    input  logic [NCPU-1:0] en_i   [NIRQ],
    input  logic [NCPU-1:0] pend_i [NIRQ],
    input  logic [NCPU-1:0] act_i  [NIRQ],
    input  logic [NCPU-1:0] lvl_i  [NIRQ],
    input  logic [NCPU-1:0] grp_i  [NIRQ],
    input  logic [NIRQ-1:0] edge_i,
    input  logic [NIRQ-1:0] model_i,
    output logic            q_enabled,
    output logic            q_pending,
    output logic            q_active,
    output logic            q_group
);

    logic level_view;

    always_comb begin
        level_view = !legacy_mode && !edge_i[q_id] && lvl_i[q_id][q_cpu];
        q_enabled  = en_i[q_id][q_cpu];
        q_pending  = pend_i[q_id][q_cpu] || level_view;
        q_active   = act_i[q_id][q_cpu];
        q_group    = grp_i[q_id][q_cpu];
    end

    // the delivery-model flag only matters to the field bank
    logic unused_model;
    assign unused_model = ^model_i;

endmodule

// File: rtl/irq_dist_state.sv
module irq_dist_state
    import irqst_pkg::*;
#(
    parameter int NCPU      = 4,
    parameter int NINTERNAL = 32,
    parameter int NIRQ      = 96,
    parameter int PRIO_W    = 8,
    parameter int IDW       = $clog2(NIRQ),
    parameter int CPUW      = $clog2(NCPU)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 legacy_mode,
    input  logic [NIRQ*NCPU-1:0] irq_line,
    input  logic                 set_valid,
    input  logic [2:0]           set_field,
    input  logic [IDW-1:0]       set_id,
    input  logic [NCPU-1:0]      set_mask,
    input  logic                 clr_valid,
    input  logic [2:0]           clr_field,
    input  logic [IDW-1:0]       clr_id,
    input  logic [NCPU-1:0]      clr_mask,
    input  logic                 ack_valid,
    input  logic [IDW-1:0]       ack_id,
    input  logic [CPUW-1:0]      ack_cpu,
    input  logic                 deact_valid,
    input  logic [IDW-1:0]       deact_id,
    input  logic [CPUW-1:0]      deact_cpu,
    input  logic                 prio_we,
    input  logic [IDW-1:0]       prio_id,
    input  logic [CPUW-1:0]      prio_cpu,
    input  logic [PRIO_W-1:0]    prio_val,
    input  logic [IDW-1:0]       q_id,
    input  logic [CPUW-1:0]      q_cpu,
    output logic                 q_enabled,
    output logic                 q_pending,
    output logic                 q_active,
    output logic                 q_group,
    output logic [PRIO_W-1:0]    q_prio
);

    logic [NCPU-1:0] en_w   [NIRQ];
    logic [NCPU-1:0] pend_w [NIRQ];
    logic [NCPU-1:0] act_w  [NIRQ];
    logic [NCPU-1:0] lvl_w  [NIRQ];
    logic [NCPU-1:0] grp_w  [NIRQ];
    logic [NIRQ-1:0] edge_w;
    logic [NIRQ-1:0] model_w;

    irqst_fields #(
        .NCPU(NCPU), .NINTERNAL(NINTERNAL), .NIRQ(NIRQ), .IDW(IDW), .CPUW(CPUW)
    ) u_fields (
        .clk(clk), .rst_n(rst_n), .irq_line(irq_line),
        .set_valid(set_valid), .set_field(set_field), .set_id(set_id), .set_mask(set_mask),
        .clr_valid(clr_valid), .clr_field(clr_field), .clr_id(clr_id), .clr_mask(clr_mask),
        .ack_valid(ack_valid), .ack_id(ack_id), .ack_cpu(ack_cpu),
        .deact_valid(deact_valid), .deact_id(deact_id), .deact_cpu(deact_cpu),
        .en_o(en_w), .pend_o(pend_w), .act_o(act_w), .lvl_o(lvl_w), .grp_o(grp_w),
        .edge_o(edge_w), .model_o(model_w)
    );

    irqst_prio #(
        .NCPU(NCPU), .NINTERNAL(NINTERNAL), .NIRQ(NIRQ), .PRIO_W(PRIO_W),
        .IDW(IDW), .CPUW(CPUW)
    ) u_prio (
        .clk(clk), .rst_n(rst_n),
        .prio_we(prio_we), .prio_id(prio_id), .prio_cpu(prio_cpu), .prio_val(prio_val),
        .rd_id(q_id), .rd_cpu(q_cpu), .rd_prio(q_prio)
    );

    irqst_query #(
        .NCPU(NCPU), .NIRQ(NIRQ), .IDW(IDW), .CPUW(CPUW)
    ) u_query (
        .legacy_mode(legacy_mode), .q_id(q_id), .q_cpu(q_cpu),
        .en_i(en_w), .pend_i(pend_w), .act_i(act_w), .lvl_i(lvl_w), .grp_i(grp_w),
        .edge_i(edge_w), .model_i(model_w),
        .q_enabled(q_enabled), .q_pending(q_pending), .q_active(q_active), .q_group(q_group)
    );

endmodule

// File: rtl/irqst_checker.sv
module irqst_checker
    import irqst_pkg::*;
#(
    parameter int NCPU      = 4,
    parameter int NINTERNAL = 32,
    parameter int PRIO_W    = 8,
    parameter int IDW       = 7,
    parameter int CPUW      = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              set_valid,
    input logic [2:0]        set_field,
    input logic [IDW-1:0]    set_id,
    input logic [NCPU-1:0]   set_mask,
    input logic              clr_valid,
    input logic [2:0]        clr_field,
    input logic [IDW-1:0]    clr_id,
    input logic [NCPU-1:0]   clr_mask,
    input logic              deact_valid,
    input logic [IDW-1:0]    deact_id,
    input logic              prio_we,
    input logic [IDW-1:0]    q_id,
    input logic [CPUW-1:0]   q_cpu,
    input logic              q_enabled,
    input logic              q_pending,
    input logic              q_active,
    input logic              q_group,
    input logic [PRIO_W-1:0] q_prio
);

    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!q_enabled && !q_pending && !q_active && !q_group && q_prio == '0));

    a_r2_group_set: assert property (@(posedge clk) disable iff (!rst_n)
        (set_valid && set_field == FLD_GROUP && set_id == q_id && set_mask[q_cpu])
        |=> (!$stable(q_id) || !$stable(q_cpu) || q_group));

    a_r3_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (set_valid && clr_valid && set_field == FLD_ENABLE && clr_field == FLD_ENABLE &&
         set_id == clr_id && set_id == q_id && set_mask[q_cpu] && clr_mask[q_cpu])
        |=> (!$stable(q_id) || !$stable(q_cpu) || q_enabled));

    a_r9_shared_deact_all: assert property (@(posedge clk) disable iff (!rst_n)
        (deact_valid && deact_id >= IDW'(NINTERNAL) && deact_id == q_id &&
         !(set_valid && set_field == FLD_ACTIVE && set_id == deact_id))
        |=> (!$stable(q_id) || !q_active));

    a_r10_prio_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !prio_we |=> (!$stable(q_id) || !$stable(q_cpu) || $stable(q_prio)));

endmodule

bind irq_dist_state irqst_checker #(
    .NCPU(NCPU), .NINTERNAL(NINTERNAL), .PRIO_W(PRIO_W), .IDW(IDW), .CPUW(CPUW)
) u_checker (
    .clk(clk), .rst_n(rst_n),
    .set_valid(set_valid), .set_field(set_field), .set_id(set_id), .set_mask(set_mask),
    .clr_valid(clr_valid), .clr_field(clr_field), .clr_id(clr_id), .clr_mask(clr_mask),
    .deact_valid(deact_valid), .deact_id(deact_id), .prio_we(prio_we),
    .q_id(q_id), .q_cpu(q_cpu), .q_enabled(q_enabled), .q_pending(q_pending),
    .q_active(q_active), .q_group(q_group), .q_prio(q_prio)
);

// File: tb/test_irq_dist_state.sv
module test_irq_dist_state;

    localparam int NC = 4;
    localparam int NI = 96;
    localparam int NINT = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        legacy_mode = 1'b0;
    logic [NI*NC-1:0] irq_line;
    logic        set_valid = 0, clr_valid = 0, ack_valid = 0, deact_valid = 0, prio_we = 0;
    logic [2:0]  set_field = 0, clr_field = 0;
    logic [6:0]  set_id = 0, clr_id = 0, ack_id = 0, deact_id = 0, prio_id = 0, q_id = 0;
    logic [3:0]  set_mask = 0, clr_mask = 0;
    logic [1:0]  ack_cpu = 0, deact_cpu = 0, prio_cpu = 0, q_cpu = 0;
    logic [7:0]  prio_val = 0;
    logic        q_enabled, q_pending, q_active, q_group;
    logic [7:0]  q_prio;

    logic [3:0] line_a [NI];

    // behavioural reference state
    logic [3:0] m_en [NI], m_pend [NI], m_act [NI], m_lvl [NI], m_grp [NI];
    logic       m_edge [NI], m_model [NI];
    logic [7:0] m_bank [NINT][NC];
    logic [7:0] m_sh [NI-NINT];

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    always #5 clk = ~clk;

    always_comb
        for (int i = 0; i < NI; i++) irq_line[i*NC +: NC] = line_a[i];

    irq_dist_state i_irq_dist_state (
        .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode), .irq_line(irq_line),
        .set_valid(set_valid), .set_field(set_field), .set_id(set_id), .set_mask(set_mask),
        .clr_valid(clr_valid), .clr_field(clr_field), .clr_id(clr_id), .clr_mask(clr_mask),
        .ack_valid(ack_valid), .ack_id(ack_id), .ack_cpu(ack_cpu),
        .deact_valid(deact_valid), .deact_id(deact_id), .deact_cpu(deact_cpu),
        .prio_we(prio_we), .prio_id(prio_id), .prio_cpu(prio_cpu), .prio_val(prio_val),
        .q_id(q_id), .q_cpu(q_cpu), .q_enabled(q_enabled), .q_pending(q_pending),
        .q_active(q_active), .q_group(q_group), .q_prio(q_prio)
    );

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s id=%0d cpu=%0d: actual %0d expected %0d",
                     tag, what, q_id, q_cpu, act, exp);
        end
    endtask

    task automatic field_op(int f, int id, logic [3:0] m, bit setv);
        case (f)
            0: m_en[id]   = setv ? (m_en[id] | m)   : (m_en[id] & ~m);
            1: m_pend[id] = setv ? (m_pend[id] | m) : (m_pend[id] & ~m);
            2: m_act[id]  = setv ? (m_act[id] | m)  : (m_act[id] & ~m);
            3: m_grp[id]  = setv ? (m_grp[id] | m)  : (m_grp[id] & ~m);
            4: m_edge[id] = setv;
            5: m_model[id] = setv;
            default: ;
        endcase
    endtask

    task automatic model_step();
        logic [3:0] rise [NI];
        for (int i = 0; i < NI; i++) rise[i] = m_edge[i] ? (line_a[i] & ~m_lvl[i]) : 4'b0;
        if (clr_valid) field_op(int'(clr_field), int'(clr_id), clr_mask, 1'b0);
        if (ack_valid) begin
            if (m_model[ack_id]) m_pend[ack_id] = 4'b0;
            else m_pend[ack_id][ack_cpu] = 1'b0;
        end
        if (deact_valid) begin
            if (deact_id < NINT) m_act[deact_id][deact_cpu] = 1'b0;
            else m_act[deact_id] = 4'b0;
        end
        if (set_valid) field_op(int'(set_field), int'(set_id), set_mask, 1'b1);
        for (int i = 0; i < NI; i++) begin
            m_pend[i] = m_pend[i] | rise[i];
            m_lvl[i]  = line_a[i];
        end
        if (prio_we) begin
            if (prio_id < NINT) m_bank[prio_id][prio_cpu] = prio_val;
            else m_sh[prio_id - NINT] = prio_val;
        end
    endtask

    task automatic compare();
        int id, c;
        bit ep;
        id = int'(q_id);
        c  = int'(q_cpu);
        ep = m_pend[id][c] || (!legacy_mode && !m_edge[id] && m_lvl[id][c]);
        chk("enabled", int'(q_enabled), int'(m_en[id][c]));
        chk("pending", int'(q_pending), int'(ep));
        chk("active",  int'(q_active),  int'(m_act[id][c]));
        chk("group",   int'(q_group),   int'(m_grp[id][c]));
        chk("prio",    int'(q_prio),
            (id < NINT) ? int'(m_bank[id][c]) : int'(m_sh[id - NINT]));
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        set_valid = 0; clr_valid = 0; ack_valid = 0; deact_valid = 0; prio_we = 0;
    endtask

    task automatic qry(int id, int c);
        q_id = 7'(id); q_cpu = 2'(c);
    endtask
    task automatic do_set(int f, int id, logic [3:0] m);
        set_valid = 1; set_field = 3'(f); set_id = 7'(id); set_mask = m;
    endtask
    task automatic do_clr(int f, int id, logic [3:0] m);
        clr_valid = 1; clr_field = 3'(f); clr_id = 7'(id); clr_mask = m;
    endtask
    task automatic do_ack(int id, int c);
        ack_valid = 1; ack_id = 7'(id); ack_cpu = 2'(c);
    endtask
    task automatic do_deact(int id, int c);
        deact_valid = 1; deact_id = 7'(id); deact_cpu = 2'(c);
    endtask
    task automatic do_prio(int id, int c, int v);
        prio_we = 1; prio_id = 7'(id); prio_cpu = 2'(c); prio_val = 8'(v);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NI; i++) begin
            line_a[i] = 0; m_en[i] = 0; m_pend[i] = 0; m_act[i] = 0;
            m_lvl[i] = 0; m_grp[i] = 0; m_edge[i] = 0; m_model[i] = 0;
        end
        for (int i = 0; i < NINT; i++)
            for (int c = 0; c < NC; c++) m_bank[i][c] = 0;
        for (int i = 0; i < NI - NINT; i++) m_sh[i] = 0;

        // R1: reset state
        tag = "R1";
        repeat (2) @(negedge clk);
        qry(40, 0); #1 compare();
        rst_n = 1;
        cyc();

        // R2: enable and group via set/clear with masks
        tag = "R2";
        qry(40, 0); do_set(0, 40, 4'b0101); cyc();
        qry(40, 1); cyc();
        qry(40, 2); do_clr(0, 40, 4'b0100); cyc();
        qry(40, 0); cyc();
        qry(41, 3); do_set(3, 41, 4'b1000); cyc();
        qry(41, 3); do_set(6, 41, 4'b1111); do_clr(7, 41, 4'b1111); cyc();

        // R3: set beats clear
        tag = "R3";
        qry(42, 2); do_set(3, 42, 4'b0100); do_clr(3, 42, 4'b0100); cyc();
        qry(43, 1); do_set(0, 43, 4'b0010); do_clr(0, 43, 4'b0010); cyc();

        // R4: level-sensitive line in normal mode
        tag = "R4";
        qry(50, 1); line_a[50] = 4'b0010; cyc();
        line_a[50] = 4'b0000; cyc();
        cyc();

        // R5: legacy mode ignores level
        tag = "R5";
        legacy_mode = 1; line_a[50] = 4'b0010; cyc(); cyc();
        do_set(1, 50, 4'b0010); cyc();
        do_clr(1, 50, 4'b0010); cyc();
        legacy_mode = 0; cyc();
        line_a[50] = 4'b0000; cyc();

        // R6: edge-triggered latching
        tag = "R6";
        qry(60, 2); do_set(4, 60, 4'b0000); cyc();
        line_a[60] = 4'b0100; cyc();
        cyc();
        do_clr(1, 60, 4'b0100); cyc();
        cyc();
        line_a[60] = 4'b0000; cyc();
        line_a[60] = 4'b0100; cyc();
        qry(60, 0); cyc();

        // R7: latch clear with line held high
        tag = "R7";
        qry(50, 1); line_a[50] = 4'b0010; do_set(1, 50, 4'b0010); cyc();
        do_clr(1, 50, 4'b0010); cyc();
        line_a[50] = 4'b0000; cyc();

        // R8: acknowledge mask depends on delivery model
        tag = "R8";
        qry(70, 3); do_set(1, 70, 4'hF); cyc();
        do_ack(70, 3); cyc();
        qry(70, 0); cyc();
        do_set(5, 70, 4'b0000); cyc();
        qry(70, 1); do_ack(70, 0); cyc();
        qry(70, 2); cyc();

        // R9: deactivate scope
        tag = "R9";
        qry(10, 2); do_set(2, 10, 4'hF); cyc();
        do_deact(10, 2); cyc();
        qry(10, 1); cyc();
        qry(80, 3); do_set(2, 80, 4'hF); cyc();
        do_deact(80, 1); cyc();
        qry(80, 1); cyc();

        // R10: banked and shared priority
        tag = "R10";
        qry(5, 1); do_prio(5, 1, 8'hA5); cyc();
        do_prio(5, 2, 8'h3C); cyc();
        qry(5, 2); cyc();
        qry(5, 0); cyc();
        qry(90, 3); do_prio(90, 3, 8'h77); cyc();
        qry(90, 0); cyc();
        qry(31, 3); do_prio(31, 3, 8'hFF); cyc();
        qry(32, 3); do_prio(32, 0, 8'h12); cyc();

        // R11: query moves without commands
        tag = "R11";
        for (int k = 0; k < 12; k++) begin
            qry((k * 37) % NI, k % NC);
            cyc();
        end

        finish_run();
    end

endmodule